// File: doc/BRIEF.md
# Row-Buffer Page Policy Predictor

This block sits beside a DRAM command scheduler and decides, once each access to a bank has completed, whether that bank's row should be closed with a precharge or left active for the next access. It does not use a fixed open-page or close-page rule. Each bank has its own two-bit saturating history machine, and that machine learns whether accesses to the bank tend to return to the same row. When the updated history predicts a row hit, the row is left open. When it predicts a row miss, the bank is marked for precharge straight after the access.

The scheduler pulses `acc_valid` with the bank and row of each completed access. One cycle later the block returns the decision, and also reports whether the access found its row already open. Per-bank open flags and the last accessed row of every bank are always visible, so the scheduler can use them for its own hit checks.

The history machine has four states, from weakest to strongest hit confidence: `ST_MISS_STRONG`, `ST_MISS_WEAK`, `ST_HIT_WEAK` and `ST_HIT_STRONG`. A training hit moves a bank one step toward `ST_HIT_STRONG`, and a training miss moves it one step toward `ST_MISS_STRONG`. The machine saturates at both ends. The two hit states predict keep-open and the two miss states predict precharge.

Training compares the new row with the last row accessed in the bank, whether or not that row is still open. A bank whose row was closed therefore still counts a return to the same row as a training hit, and it can climb back into a keep-open state. After reset, or before a bank has seen any access, the first access counts as a training miss. The reported row hit is stricter: the row must still be open.

Top module: `ppp_predictor`

## Requirements
- R1: After reset, every `open_valid` bit is 0, `dec_valid` is 0, and every bank's history state is `ST_HIT_WEAK`.
- R2: `dec_hit` is 1 only when the bank's row was open (`open_valid` set) and the stored row equals `acc_row`.
- R3: The training outcome is a hit when the bank has been accessed since reset and `acc_row` equals its last accessed row; otherwise it is a miss. A hit moves the history one step in the order SM→WM→WH→SH, and a miss moves it one step in the opposite direction.
- R4: `dec_close` is 1 exactly when the updated history state is `ST_MISS_STRONG` or `ST_MISS_WEAK`.
- R5: After a decision with `dec_close`=1, `open_valid` for that bank is 0.
- R6: After a decision with `dec_close`=0, `open_valid` for that bank is 1 and its `open_row` field equals the accessed row. `open_row` always holds the last accessed row of each bank, with bank b at bits [b*ROW_W +: ROW_W].
- R7: An access changes neither the history nor the open flag nor the stored row of any other bank. A cycle without `acc_valid` changes nothing.
- R8: `dec_valid`, `dec_close`, `dec_hit` and `dec_bank` are registered. They are presented in the cycle after `acc_valid`, and `dec_valid` is 0 in the cycle after a cycle without `acc_valid`.
- R9: The history saturates. A hit in `ST_HIT_STRONG` stays there, and a miss in `ST_MISS_STRONG` stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One access has completed this cycle |
| acc_bank | input | BANK_W | Bank of the completed access |
| acc_row | input | ROW_W | Row of the completed access |
| dec_valid | output | 1 | Decision present this cycle |
| dec_close | output | 1 | 1 = precharge the bank, 0 = keep the row open |
| dec_hit | output | 1 | The access found its row already open |
| dec_bank | output | BANK_W | Bank the decision refers to |
| open_valid | output | NUM_BANKS | Per-bank row-open flags |
| open_row | output | NUM_BANKS*ROW_W | Per-bank last accessed row, packed by bank |

## Verification
The bench walks one bank through every history state and holds it at both saturated ends. A design with off-by-one saturation would either wrap around or stall one step short, and the decision sequence would show it. A repeat of a row after a precharge is checked for a training hit together with `dec_hit`=0, which exposes a design that merges the open-row check with the history check, or one that never recovers from the miss states. Interleaved accesses to several banks, including back-to-back cycles and idle gaps, catch a design that trains or clears the wrong bank or that raises `dec_valid` during idle cycles. A seeded random stream over a small row set then mixes hits and misses across all banks.

// File: rtl/ppp_pkg.sv
package ppp_pkg;
    typedef enum logic [1:0] {
        ST_MISS_STRONG = 2'd0,
        ST_MISS_WEAK   = 2'd1,
        ST_HIT_WEAK    = 2'd2,
        ST_HIT_STRONG  = 2'd3
    } hist_t;

    localparam hist_t HIST_RESET = ST_HIT_WEAK;
endpackage

// File: rtl/ppp_hist_fsm.sv
module ppp_hist_fsm
    import ppp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  train_en,
    input  logic  train_hit,
    output hist_t state,
    output logic  next_keep
);
    hist_t state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= HIST_RESET;
        else if (train_en)
            state <= state_nx;
    end

    // next-state and prediction
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_MISS_STRONG: state_nx = train_hit ? ST_MISS_WEAK  : ST_MISS_STRONG;
            ST_MISS_WEAK:   state_nx = train_hit ? ST_HIT_WEAK   : ST_MISS_STRONG;
            ST_HIT_WEAK:    state_nx = train_hit ? ST_HIT_STRONG : ST_MISS_WEAK;
            ST_HIT_STRONG:  state_nx = train_hit ? ST_HIT_STRONG : ST_HIT_WEAK;
            default:        state_nx = HIST_RESET;
        endcase
        next_keep = (state_nx == ST_HIT_WEAK) || (state_nx == ST_HIT_STRONG);
    end

    // R9
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && train_hit && state == ST_HIT_STRONG) |=> state == ST_HIT_STRONG);
    // R9
    sat_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && !train_hit && state == ST_MISS_STRONG) |=> state == ST_MISS_STRONG);
    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && !train_hit && state == ST_HIT_WEAK) |=> state == ST_MISS_WEAK);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !train_en |=> $stable(state));
endmodule

// File: rtl/ppp_row_track.sv
module ppp_row_track #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic             keep,
    input  logic [ROW_W-1:0] row_in,
    output logic             seen,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen    <= 1'b0;
            is_open <= 1'b0;
            row_q   <= '0;
        end else if (upd_en) begin
            seen    <= 1'b1;
            is_open <= keep;
            row_q   <= row_in;
        end
    end

    // R5
    close_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !keep) |=> !is_open);
    // R6
    keep_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && keep) |=> (is_open && row_q == $past(row_in)));
endmodule

// File: rtl/ppp_predictor.sv
module ppp_predictor
    import ppp_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_valid,
    input  logic [BANK_W-1:0]          acc_bank,
    input  logic [ROW_W-1:0]           acc_row,
    output logic                       dec_valid,
    output logic                       dec_close,
    output logic                       dec_hit,
    output logic [BANK_W-1:0]          dec_bank,
    output logic [NUM_BANKS-1:0]       open_valid,
    output logic [NUM_BANKS*ROW_W-1:0] open_row
);
    logic [NUM_BANKS-1:0] seen_v;
    logic [NUM_BANKS-1:0] keep_v;
    logic [NUM_BANKS-1:0] sel_v;
    logic [NUM_BANKS-1:0] match_v;
    logic                 sel_keep;
    logic                 sel_hit;
    hist_t                hist_s [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign sel_v[b]   = acc_valid && (acc_bank == BANK_W'(b));
        assign match_v[b] = (open_row[b*ROW_W +: ROW_W] == acc_row);

        ppp_hist_fsm u_hist (
            .clk       (clk),
            .rst_n     (rst_n),
            .train_en  (sel_v[b]),
            .train_hit (seen_v[b] && match_v[b]),
            .state     (hist_s[b]),
            .next_keep (keep_v[b])
        );

        ppp_row_track #(.ROW_W(ROW_W)) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (sel_v[b]),
            .keep    (keep_v[b]),
            .row_in  (acc_row),
            .seen    (seen_v[b]),
            .is_open (open_valid[b]),
            .row_q   (open_row[b*ROW_W +: ROW_W])
        );
    end

    always_comb begin
        sel_keep = 1'b0;
        sel_hit  = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (acc_bank == BANK_W'(b)) begin
                sel_keep = keep_v[b];
                sel_hit  = open_valid[b] && match_v[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_close <= 1'b0;
            dec_hit   <= 1'b0;
            dec_bank  <= '0;
        end else begin
            dec_valid <= acc_valid;
            if (acc_valid) begin
                dec_close <= !sel_keep;
                dec_hit   <= sel_hit;
                dec_bank  <= acc_bank;
            end
        end
    end

    // R8
    dec_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> dec_valid);
    // R8
    dec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !dec_valid);
    // R5
    closed_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_close) |-> !open_valid[dec_bank]);
    // R2
    hit_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !open_valid[acc_bank]) |=> !dec_hit);
    // R7
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> ($stable(open_valid) && $stable(open_row)));
endmodule

// File: tb/ppp_predictor_test.sv
`timescale 1ns/1ps
module ppp_predictor_test;
    localparam int NB = 8;
    localparam int RW = 14;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [BW-1:0] acc_bank = '0;
    logic [RW-1:0] acc_row = '0;
    logic          dec_valid, dec_close, dec_hit;
    logic [BW-1:0] dec_bank;
    logic [NB-1:0] open_valid;
    logic [NB*RW-1:0] open_row;

    int tests = 0;
    int fails = 0;

    int            m_st   [NB];
    bit            m_seen [NB];
    bit            m_open [NB];
    logic [RW-1:0] m_row  [NB];

    always #2.5 clk = ~clk;

    ppp_predictor #(.NUM_BANKS(NB), .ROW_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_bank(acc_bank),
        .acc_row(acc_row), .dec_valid(dec_valid), .dec_close(dec_close),
        .dec_hit(dec_hit), .dec_bank(dec_bank), .open_valid(open_valid),
        .open_row(open_row)
    );

    function automatic int step(int s, bit h);
        if (h) return (s == 3) ? 3 : s + 1;
        return (s == 0) ? 0 : s - 1;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_banks(string req);
        for (int b = 0; b < NB; b++) begin
            chk(req, $sformatf("open_valid[%0d]", b), open_valid[b], m_open[b]);
            chk(req, $sformatf("open_row[%0d]", b), open_row[b*RW +: RW], m_row[b]);
        end
    endtask

    // drive at negedge, check at the following negedge
    task automatic access(int b, logic [RW-1:0] r, string req);
        bit th, rh, keep;
        int ns;
        th = m_seen[b] && (m_row[b] == r);
        rh = m_open[b] && (m_row[b] == r);
        ns = step(m_st[b], th);
        keep = (ns >= 2);
        m_st[b] = ns; m_seen[b] = 1'b1; m_open[b] = keep; m_row[b] = r;
        acc_valid = 1'b1; acc_bank = BW'(b); acc_row = r;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R8", "dec_valid", dec_valid, 1);
        chk("R8", "dec_bank", dec_bank, b);
        chk(req, "dec_close R4", dec_close, !keep);
        chk(req, "dec_hit R2", dec_hit, rh);
        chk_banks(keep ? "R6" : "R5");
    endtask

    task automatic idle();
        @(negedge clk);
        chk("R8", "dec_valid idle", dec_valid, 0);
        chk_banks("R7");
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < NB; b++) begin
            m_st[b] = 2; m_seen[b] = 0; m_open[b] = 0; m_row[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "dec_valid", dec_valid, 0);
        chk_banks("R1");
        // directed walk on bank 0 (R3, R4, R9)
        access(0, 14'd5, "R3");   // WH->WM close, first access miss
        access(0, 14'd5, "R3");   // WM->WH keep, row was closed: no hit
        access(0, 14'd5, "R2");   // WH->SH, real hit
        access(0, 14'd5, "R9");   // SH saturates
        idle();
        access(1, 14'd7, "R7");   // other bank: bank 0 untouched
        access(0, 14'd9, "R3");   // SH->WH keep, miss
        access(0, 14'd3, "R4");   // WH->WM close
        access(0, 14'd4, "R3");   // WM->SM
        access(0, 14'd6, "R9");   // SM saturates
        access(0, 14'd6, "R3");   // SM->WM, still close
        access(0, 14'd6, "R3");   // WM->WH keep again
        idle();
        // random mix
        for (int i = 0; i < 400; i++) begin
            int b;
            logic [RW-1:0] r;
            b = int'($urandom % NB);
            r = RW'($urandom % 3);
            access(b, r, "R3");
            if (($urandom % 4) == 0) idle();
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule